// File: doc/BRIEF.md
# Boundary-Delimited Multibyte Register Arithmetic Unit

This block is a 64-entry, byte-wide register file with a byte-serial add/subtract engine. A single start request names a destination register and a source register. The engine then works through a multibyte field, one byte per clock, in binary or packed-BCD arithmetic. The carry or borrow is chained from each byte into the next. The operation does not carry a length. Instead, the field runs from the addressed register up to the next fixed boundary. The lower half of the map has a boundary every two registers. The upper half has a boundary every eight registers. A start on register 32 therefore processes eight bytes, and a start on register 37 processes three.

The result goes back into the destination field, so any register can serve as the accumulator. The lowest-addressed byte of a field is the least significant one. A host port loads registers while the engine is idle. The same port always reads an adjacent register pair as one 16-bit value. Busy and done show the progress of an operation. Carry and zero flags summarise the last completed operation.

Top module: `mbf_alu`

## Requirements
- R1: After reset, busy_o, done_o, carry_o and zero_o are all low.
- R2: A field that starts at a register below 32 is 2 − (addr mod 2) bytes long. Registers outside the destination field keep their contents.
- R3: A field that starts at register 32 or above is 8 − (addr mod 8) bytes long, so one start adds two eight-byte values.
- R4: With op_sub_i=0 and mode_bcd_i=0, the destination field becomes destination + source as an unsigned little-endian number. The carry into the first byte is 0.
- R5: With op_sub_i=1 and mode_bcd_i=0, the destination field becomes destination − source. A borrow is chained between bytes, and carry_o=1 means a borrow came out of the last byte.
- R6: With op_sub_i=0 and mode_bcd_i=1, every byte holds two decimal digits, the low digit in bits 3:0. The field is added digit by digit with a decimal carry.
- R7: With op_sub_i=1 and mode_bcd_i=1, the field is subtracted digit by digit with a decimal borrow. Borrowing past the last digit wraps the result (0 − 1 gives all nines) and sets carry_o.
- R8: zero_o is set only if every result byte of the field is zero. carry_o holds the carry or borrow out of the final byte. Both flags hold until the next operation completes.
- R9: The destination field sets the length. When the source field is shorter, its bytes past the source boundary count as zero.
- R10: busy_o rises in the cycle after start is accepted. done_o is high for exactly one cycle, N clock edges after the accepting edge, where N is the field length.
- R11: While busy, a start request and a host write are both ignored.
- R12: host_rdata_o returns {reg[addr+1], reg[addr]}, and the address above 63 wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| dst_i | input | 6 | Destination field start register |
| src_i | input | 6 | Source field start register |
| op_sub_i | input | 1 | 0 add, 1 subtract |
| mode_bcd_i | input | 1 | 0 binary, 1 packed BCD |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Carry/borrow out of last operation |
| zero_o | output | 1 | Whole result field was zero |
| host_we_i | input | 1 | Host write enable (idle only) |
| host_addr_i | input | 6 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 16 | Register pair {addr+1, addr} |

## Verification
The bench builds the block with its default values: 64 registers, 32 of them in the two-byte bank, and a span of eight in the upper bank. With these values it can reach every field length from one to eight. It can also reach the boundary registers 31, 32 and 63, and the pair-read wrap from 63 to 0. Random operations pick start registers in both banks, so source and destination fields of unequal length meet often, and so do fields that overlap. Directed cases cover carry through a full eight-byte field, wrap-around in decimal, and starts and host writes during a busy period.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} eng_state_t;
endpackage

// File: rtl/mbf_regfile.sv
module mbf_regfile #(
  parameter int NREGS = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_d_i,
  input  logic [AW-1:0] ra_s_i,
  input  logic [AW-1:0] ra_h_i,
  output logic [DW-1:0] rd_d_o,
  output logic [DW-1:0] rd_s_o,
  output logic [2*DW-1:0] rd_h_o
);
  logic [DW-1:0] mem [NREGS];
  logic [AW-1:0] ra_h_nxt;

  // storage is not reset; contents are defined by host loads
  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  assign ra_h_nxt = ra_h_i + AW'(1);
  assign rd_d_o   = mem[ra_d_i];
  assign rd_s_o   = mem[ra_s_i];
  assign rd_h_o   = {mem[ra_h_nxt], mem[ra_h_i]};
endmodule

// File: rtl/mbf_span.sv
module mbf_span #(
  parameter int NREGS    = 64,
  parameter int LO_COUNT = 32,
  parameter int LO_SPAN  = 2,
  parameter int HI_SPAN  = 8,
  localparam int AW      = $clog2(NREGS),
  localparam int LENW    = $clog2(HI_SPAN) + 1
) (
  input  logic [AW-1:0]   addr_i,
  output logic [LENW-1:0] len_o
);
  localparam logic [AW-1:0] LO_MASK = AW'(LO_SPAN - 1);
  localparam logic [AW-1:0] HI_MASK = AW'(HI_SPAN - 1);

  logic [AW-1:0] off;
  logic          in_lo;

  assign in_lo = ({1'b0, addr_i} < (AW+1)'(LO_COUNT));

  always_comb begin
    if (in_lo) begin
      off   = addr_i & LO_MASK;
      len_o = LENW'(LO_SPAN) - LENW'(off);
    end else begin
      off   = addr_i & HI_MASK;
      len_o = LENW'(HI_SPAN) - LENW'(off);
    end
  end
endmodule

// File: rtl/mbf_byte_alu.sv
module mbf_byte_alu #(
  parameter int DW     = 8,
  parameter bit BCD_EN = 1'b1,
  localparam int NIB   = DW / 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          ci_i,
  input  logic          sub_i,
  input  logic          bcd_i,
  output logic [DW-1:0] res_o,
  output logic          co_o
);
  logic [DW:0]   bin_raw;
  logic [DW-1:0] dec_res;
  logic          dec_co;

  always_comb begin
    if (sub_i) bin_raw = {1'b0, a_i} - {1'b0, b_i} - (DW+1)'(ci_i);
    else       bin_raw = {1'b0, a_i} + {1'b0, b_i} + (DW+1)'(ci_i);
  end

  generate
    if (BCD_EN) begin : g_dec
      always_comb begin
        logic       c;
        logic [4:0] raw;
        c       = ci_i;
        dec_res = '0;
        for (int i = 0; i < NIB; i++) begin
          if (!sub_i) begin
            raw = {1'b0, a_i[4*i +: 4]} + {1'b0, b_i[4*i +: 4]} + {4'b0, c};
            if (raw > 5'd9) begin
              dec_res[4*i +: 4] = 4'(raw + 5'd6);
              c = 1'b1;
            end else begin
              dec_res[4*i +: 4] = raw[3:0];
              c = 1'b0;
            end
          end else begin
            raw = {1'b0, a_i[4*i +: 4]} - {1'b0, b_i[4*i +: 4]} - {4'b0, c};
            if (raw[4]) begin
              dec_res[4*i +: 4] = 4'(raw - 5'd6);
              c = 1'b1;
            end else begin
              dec_res[4*i +: 4] = raw[3:0];
              c = 1'b0;
            end
          end
        end
        dec_co = c;
      end
    end else begin : g_nodec
      assign dec_res = bin_raw[DW-1:0];
      assign dec_co  = bin_raw[DW];
    end
  endgenerate

  assign res_o = bcd_i ? dec_res : bin_raw[DW-1:0];
  assign co_o  = bcd_i ? dec_co  : bin_raw[DW];
endmodule

// File: rtl/mbf_alu.sv
module mbf_alu #(
  parameter int NREGS    = 64,
  parameter int DW       = 8,
  parameter int LO_COUNT = 32,
  parameter int LO_SPAN  = 2,
  parameter int HI_SPAN  = 8,
  localparam int AW      = $clog2(NREGS),
  localparam int LENW    = $clog2(HI_SPAN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [AW-1:0]   src_i,
  input  logic            op_sub_i,
  input  logic            mode_bcd_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            carry_o,
  output logic            zero_o,
  input  logic            host_we_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic [2*DW-1:0] host_rdata_o
);
  import mbf_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  eng_state_t      state_q, state_d;
  logic [AW-1:0]   dst_q, dst_d, src_q, src_d;
  logic [LENW-1:0] len_q, len_d, slen_q, slen_d, cnt_q, cnt_d;
  logic            sub_q, sub_d, bcd_q, bcd_d;
  logic            chain_q, chain_d, zacc_q, zacc_d;
  logic            done_q, done_d, carry_q, carry_d, zero_q, zero_d;
  logic            ctl_en;

  logic [LENW-1:0] dlen, slen;
  logic [AW-1:0]   step_dst, step_src, wa;
  logic [DW-1:0]   rd_dst, rd_src, opnd_b, alu_res, wd;
  logic            alu_co, step_zero, last_step, eng_we, host_ok, we;

  mbf_span #(.NREGS(NREGS), .LO_COUNT(LO_COUNT), .LO_SPAN(LO_SPAN), .HI_SPAN(HI_SPAN))
    u_span_dst (.addr_i(dst_i), .len_o(dlen));
  mbf_span #(.NREGS(NREGS), .LO_COUNT(LO_COUNT), .LO_SPAN(LO_SPAN), .HI_SPAN(HI_SPAN))
    u_span_src (.addr_i(src_i), .len_o(slen));

  assign step_dst  = dst_q + AW'(cnt_q);
  assign step_src  = src_q + AW'(cnt_q);
  assign opnd_b    = (cnt_q < slen_q) ? rd_src : '0;
  assign last_step = (cnt_q == len_q - LENW'(1));

  mbf_byte_alu #(.DW(DW), .BCD_EN(1'b1)) u_alu (
    .a_i(rd_dst), .b_i(opnd_b), .ci_i(chain_q), .sub_i(sub_q), .bcd_i(bcd_q),
    .res_o(alu_res), .co_o(alu_co)
  );

  assign step_zero = (alu_res == '0);
  assign eng_we    = (state_q == ST_RUN);
  assign host_ok   = host_we_i && (state_q == ST_IDLE);
  assign we        = eng_we || host_ok;
  assign wa        = eng_we ? step_dst : host_addr_i;
  assign wd        = eng_we ? alu_res  : host_wdata_i;

  mbf_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
    .clk(clk), .we_i(we), .wa_i(wa), .wd_i(wd),
    .ra_d_i(step_dst), .ra_s_i(step_src), .ra_h_i(host_addr_i),
    .rd_d_o(rd_dst), .rd_s_o(rd_src), .rd_h_o(host_rdata_o)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    dst_d   = dst_q;   src_d  = src_q;
    len_d   = len_q;   slen_d = slen_q;
    cnt_d   = cnt_q;
    sub_d   = sub_q;   bcd_d  = bcd_q;
    chain_d = chain_q; zacc_d = zacc_q;
    carry_d = carry_q; zero_d = zero_q;
    done_d  = 1'b0;
    ctl_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctl_en  = 1'b1;
          state_d = ST_RUN;
          dst_d   = dst_i;    src_d  = src_i;
          len_d   = dlen;     slen_d = slen;
          sub_d   = op_sub_i; bcd_d  = mode_bcd_i;
          cnt_d   = '0;
          chain_d = 1'b0;
          zacc_d  = 1'b1;
        end
      end
      default: begin
        ctl_en  = 1'b1;
        cnt_d   = cnt_q + LENW'(1);
        chain_d = alu_co;
        zacc_d  = zacc_q & step_zero;
        if (last_step) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          carry_d = alu_co;
          zero_d  = zacc_q & step_zero;
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      carry_q <= carry_d;
      zero_q  <= zero_d;
    end
  end

  // operation context, loaded under clock enable
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dst_q <= '0; src_q <= '0; len_q <= LENW'(1); slen_q <= LENW'(1);
      cnt_q <= '0; sub_q <= 1'b0; bcd_q <= 1'b0; chain_q <= 1'b0; zacc_q <= 1'b0;
    end else if (ctl_en) begin
      dst_q <= dst_d; src_q <= src_d; len_q <= len_d; slen_q <= slen_d;
      cnt_q <= cnt_d; sub_q <= sub_d; bcd_q <= bcd_d; chain_q <= chain_d; zacc_q <= zacc_d;
    end
  end

  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = done_q;
  assign carry_o = carry_q;
  assign zero_o  = zero_q;

  // assertions
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);
  p_done_after_run_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> ($past(busy_o) && !busy_o));
  p_cnt_in_field_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |-> (cnt_q < len_q && len_q != '0));
  p_upper_len_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && start_i && {1'b0, dst_i} >= (AW+1)'(LO_COUNT))
      |=> (len_q == LENW'(HI_SPAN) - LENW'(dst_i[$clog2(HI_SPAN)-1:0] == '0 ? 0 : 0)
           - LENW'($past(dst_i) & AW'(HI_SPAN - 1))));
  p_zero_last_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && zero_o) |-> ($past(wd) == '0));
  p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && start_i && !last_step) |=> (busy_o && $stable(dst_q) && $stable(len_q)));
  p_no_host_write_busy_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |-> (wa == step_dst));
endmodule

// File: tb/sim_mbf_alu.sv
module sim_mbf_alu;
  logic        clk, rst_n, start, sub, bcd, host_we;
  logic [5:0]  dst, src, host_addr;
  logic [7:0]  host_wdata;
  logic [15:0] host_rdata;
  logic        busy, done, carry, zero;

  int checks = 0, errors = 0;
  logic [7:0] mdl [64];

  mbf_alu u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dst_i(dst), .src_i(src),
    .op_sub_i(sub), .mode_bcd_i(bcd), .busy_o(busy), .done_o(done),
    .carry_o(carry), .zero_o(zero), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int flen(input int a);
    return (a < 32) ? 2 - (a % 2) : 8 - (a % 8);
  endfunction

  function automatic logic [7:0] rnd_byte(input bit dec);
    if (dec) return {4'($urandom_range(9)), 4'($urandom_range(9))};
    return 8'($urandom);
  endfunction

  task automatic model_op(input int d, input int s, input bit sb, input bit dec,
                          output bit c_out, output bit z_out);
    int len, sl, a, b, t, da, db, r;
    bit c;
    len = flen(d); sl = flen(s); c = 0; z_out = 1;
    for (int k = 0; k < len; k++) begin
      a = mdl[d + k];
      b = (k < sl) ? int'(mdl[s + k]) : 0;
      if (!dec) begin
        t = sb ? a - b - int'(c) : a + b + int'(c);
        c = sb ? (t < 0) : (t > 255);
        r = t & 255;
      end else begin
        r = 0;
        for (int n = 0; n < 2; n++) begin
          da = (a >> (4 * n)) & 15;
          db = (b >> (4 * n)) & 15;
          t  = sb ? da - db - int'(c) : da + db + int'(c);
          if (sb) begin c = (t < 0); if (t < 0) t += 10; end
          else begin c = (t >= 10); if (t >= 10) t -= 10; end
          r = r | (t << (4 * n));
        end
      end
      mdl[d + k] = 8'(r);
      if (r != 0) z_out = 0;
    end
    c_out = c;
  endtask

  task automatic setreg(input int a, input logic [7:0] v);
    @(negedge clk);
    host_we = 1'b1; host_addr = 6'(a); host_wdata = v;
    mdl[a] = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic load_all(input bit dec);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = 6'(a); host_wdata = rnd_byte(dec);
      mdl[a] = host_wdata;
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic compare_all(input string req);
    int bad = -1;
    @(negedge clk);
    for (int a = 0; a < 64; a++) begin
      host_addr = 6'(a);
      #1;
      if (bad < 0 && host_rdata[7:0] !== mdl[a]) bad = a;
    end
    if (bad >= 0) begin
      host_addr = 6'(bad); #1;
      chk(1'b0, req, int'(host_rdata[7:0]), int'(mdl[bad]));
    end else chk(1'b1, req, 0, 0);
  endtask

  task automatic do_op(input int d, input int s, input bit sb, input bit dec,
                       input bit inject, input string req);
    bit ec, ez;
    int n, len, ha;
    len = flen(d);
    model_op(d, s, sb, dec, ec, ez);
    ha = (d >= 32) ? 0 : 63;
    @(negedge clk);
    start = 1'b1; dst = 6'(d); src = 6'(s); sub = sb; bcd = dec;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy after accept", int'(busy), 1);
    if (inject) begin
      start = 1'b1; dst = 6'((d + 16) % 64); src = 6'(d); sub = ~sb;
      host_we = 1'b1; host_addr = 6'(ha); host_wdata = ~mdl[ha];
    end
    n = 0;
    while (done !== 1'b1 && n < 20) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0; host_we = 1'b0;
    end
    chk(n == len, "R10 done latency", n, len);
    chk(carry === ec, {req, " R8 carry"}, int'(carry), int'(ec));
    chk(zero === ez, {req, " R8 zero"}, int'(zero), int'(ez));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10 done one cycle", int'(done), 0);
    compare_all(req);
  endtask

  initial begin
    bit ok;
    void'($urandom(32'h1d5e_a7c3));
    rst_n = 1'b0; start = 1'b0; dst = '0; src = '0; sub = 1'b0; bcd = 1'b0;
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, done, carry, zero} === 4'b0, "R1 reset flags", int'({busy, done, carry, zero}), 0);

    // R2 lower bank lengths and untouched neighbours
    load_all(1'b0);
    do_op(10, 20, 1'b0, 1'b0, 1'b0, "R2 lower len2");
    do_op(11, 21, 1'b0, 1'b0, 1'b0, "R2 lower len1");
    do_op(31, 5, 1'b1, 1'b0, 1'b0, "R2 last lower reg");

    // R3 / R4 eight-byte binary carry ripple
    for (int k = 0; k < 8; k++) begin setreg(32 + k, 8'hFF); setreg(48 + k, (k == 0) ? 8'h01 : 8'h00); end
    do_op(32, 48, 1'b0, 1'b0, 1'b0, "R3 R4 full ripple");
    do_op(39, 40, 1'b0, 1'b0, 1'b0, "R3 len1 at 39");
    do_op(45, 56, 1'b0, 1'b0, 1'b0, "R3 len3 at 45");

    // R5 subtract equal -> zero, no borrow; then borrow out
    for (int k = 0; k < 8; k++) begin setreg(40 + k, 8'(k * 37)); setreg(56 + k, 8'(k * 37)); end
    do_op(40, 56, 1'b1, 1'b0, 1'b0, "R5 equal sub");
    do_op(40, 56, 1'b1, 1'b0, 1'b0, "R5 borrow out");

    // R6 decimal add 99..99 + 1
    for (int k = 0; k < 8; k++) begin setreg(32 + k, 8'h99); setreg(48 + k, (k == 0) ? 8'h01 : 8'h00); end
    do_op(32, 48, 1'b0, 1'b1, 1'b0, "R6 decimal ripple");
    // R7 decimal 0 - 1 -> all nines with borrow
    do_op(32, 48, 1'b1, 1'b1, 1'b0, "R7 decimal wrap");

    // R9 short source under long destination
    load_all(1'b0);
    do_op(40, 30, 1'b0, 1'b0, 1'b0, "R9 short source");
    do_op(56, 13, 1'b1, 1'b0, 1'b0, "R9 len1 source");

    // R11 start and host write during busy
    load_all(1'b0);
    do_op(48, 32, 1'b0, 1'b0, 1'b1, "R11 ignore while busy len8");
    do_op(7, 3, 1'b0, 1'b0, 1'b1, "R11 ignore while busy len1");

    // R12 pair read with wrap
    setreg(63, 8'hA5); setreg(0, 8'h3C); setreg(10, 8'h12); setreg(11, 8'h34);
    @(negedge clk); host_addr = 6'd63; #1;
    chk(host_rdata === 16'h3CA5, "R12 pair wrap", int'(host_rdata), 16'h3CA5);
    host_addr = 6'd10; #1;
    chk(host_rdata === 16'h3412, "R12 pair read", int'(host_rdata), 16'h3412);

    // random mix
    for (int i = 0; i < 110; i++) begin
      bit dec;
      dec = 1'($urandom_range(1));
      load_all(dec);
      do_op($urandom_range(63), $urandom_range(63), 1'($urandom_range(1)), dec, 1'b0,
            dec ? "R6 R7 random decimal" : "R4 R5 random binary");
    end

    ok = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule